// File: doc/BRIEF.md
# Storage Channel Adapter Register Front End

This block is the register face of a mass-storage channel adapter. Software reaches it with 32-bit longword accesses. Each access is sorted into one of three classes. Adapter-internal registers hold configuration, control, status, the transfer virtual address, the byte count and a diagnostic word. Drive-side registers are passed on to a per-drive port. Map entries live in a small local RAM.

The block applies the interlock rules that keep software from disturbing a transfer in progress. While the transfer engine is busy, some writes are refused and recorded as a program error:
- a new data-transfer start,
- a write to the address register,
- a write to the byte-count register,
- setting the maintenance bit.

The transfer engine is outside this block. It sees a busy level, it receives an abort strobe, and it reports completion with a done pulse. Every access gets a registered response one cycle later: read data, a non-existent-memory flag or an error-confirmation flag.

Top module: `chan_adapter_regs`

## Requirements
- R1: An access with `acc_long`=0 or with `acc_addr[1:0]`≠0 is not performed. The response that follows it raises `err_confirm` without `rsp_nxm`, and the access sets the fault flag at bit 16 of the configuration register.
- R2: Address bits 11:10 select the class: 0 = internal, 1 = drive, 2 = map, 3 = none. For internal accesses, bits 9:2 are the offset: 0 configuration, 1 control, 2 status, 3 diagnostic, 4 address, 5 byte count, 6 command. The following give `rsp_nxm`: any other internal offset, class 3, and a map index (bits 9:2) at or above the map depth.
- R3: Status bits 19:16 (program error 19, non-existent drive 18, aborted 17, done 16) are write-one-to-clear. Configuration bit 16 is also write-one-to-clear. A hardware set in the same cycle as a clear wins.
- R4: Control bit 0 (init) returns all adapter registers and busy to reset. Control bit 1 (abort) while busy pulses `xfer_abort` for one cycle and sets status bit 17. When idle, the abort bit does nothing.
- R5: Writing control bit 2 (maintenance) as 1 while busy sets program error, and the maintenance bit stays 0. `irq` rises when a transfer completes with control bit 3 (interrupt enable) set. Writing bit 3 as 0 drops any pending interrupt.
- R6: A write to the address register or the byte-count register while busy leaves it unchanged and sets program error.
- R7: A drive write to register index 0 with bit 0 (GO) set and function bits 5:1 ≥ `DT_FN` starts a transfer. If busy, it is not forwarded and sets program error. If the drive accepts it, busy (status bit 31) is set and status bits 19:16 are cleared.
- R8: A drive access answered with `drv_missing` sets status bit 18. One answered with `drv_noreg` gives `rsp_nxm`.
- R9: A drive read returns the 16-bit drive value in bits 15:0 and status bits 31:16 in bits 31:16. Those upper bits include a flag raised by that same access.
- R10: The byte-count read returns the count in bits 15:0 and again in bits 31:16. The command register reads 0. A configuration read returns `TYPE_CODE` in bits 7:0. The address register keeps `VA_W` bits and the diagnostic register keeps 16 bits.
- R11: Map entries store and return the low `MAP_W` bits of the written word.
- R12: The response to an access made in cycle t appears in cycle t+1 with `rsp_valid`. The drive port is driven combinationally in cycle t.
- R13: `xfer_done` while busy clears busy and sets status bit 16. Busy refusals are judged on the busy state at the start of the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_long | input | 1 | 1 = longword-sized access |
| acc_addr | input | 12 | Byte address within the adapter |
| acc_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid (one cycle after the access) |
| rsp_rdata | output | 32 | Read data |
| rsp_nxm | output | 1 | Non-existent-memory response |
| err_confirm | output | 1 | Malformed-access error confirmation |
| drv_sel | output | 1 | Drive register access forwarded |
| drv_write | output | 1 | Drive access is a write |
| drv_unit | output | 3 | Drive number |
| drv_index | output | 5 | Drive register index |
| drv_wdata | output | 16 | Drive write data |
| drv_rdata | input | 16 | Drive read data (same cycle) |
| drv_missing | input | 1 | Addressed drive absent |
| drv_noreg | input | 1 | Addressed drive register absent |
| xfer_busy | output | 1 | Transfer in progress |
| xfer_abort | output | 1 | One-cycle abort strobe to the engine |
| xfer_done | input | 1 | Engine reports transfer completion |
| irq | output | 1 | Pending adapter interrupt |

## Verification
The completion pulse from the engine can land in the same cycle as a software write that depends on busy. The bench provokes this in two ways. First, it raises `xfer_done` together with an address-register write during a transfer. The write must be refused with program error, and busy must still fall and done must still be set. Second, it raises `xfer_done` together with a write-one-to-clear of the done bit. The status read afterwards must show done set, because the hardware set wins.

// File: rtl/cad_pkg.sv
`timescale 1ns/1ps
package cad_pkg;
    localparam int ADDR_W = 12;

    typedef enum logic [1:0] {
        CLS_INT  = 2'd0,
        CLS_DRV  = 2'd1,
        CLS_MAP  = 2'd2,
        CLS_NONE = 2'd3
    } acc_class_e;

    localparam logic [7:0] OFS_CFG   = 8'd0;
    localparam logic [7:0] OFS_CTL   = 8'd1;
    localparam logic [7:0] OFS_STS   = 8'd2;
    localparam logic [7:0] OFS_DIAG  = 8'd3;
    localparam logic [7:0] OFS_VADDR = 8'd4;
    localparam logic [7:0] OFS_BCNT  = 8'd5;
    localparam logic [7:0] OFS_CMD   = 8'd6;

    localparam int CTL_INIT  = 0;
    localparam int CTL_ABORT = 1;
    localparam int CTL_MAINT = 2;
    localparam int CTL_IE    = 3;

    localparam int CFG_FAULT = 16;
    localparam int STS_DONE  = 16;
    localparam int STS_ABT   = 17;
    localparam int STS_NXD   = 18;
    localparam int STS_PGE   = 19;
    localparam int STS_BUSY  = 31;

    localparam logic [31:0] STS_W1C = 32'h000F_0000;
endpackage

// File: rtl/cad_decode.sv
`timescale 1ns/1ps
module cad_decode
    import cad_pkg::*;
(
    input  logic              valid,
    input  logic              long_sz,
    input  logic [ADDR_W-1:0] addr,
    output logic              fault,
    output acc_class_e        cls,
    output logic [7:0]        idx,
    output logic [2:0]        unit,
    output logic [4:0]        dreg
);
    always_comb begin
        fault = valid && (!long_sz || (addr[1:0] != 2'b00));
        cls   = acc_class_e'(addr[ADDR_W-1:ADDR_W-2]);
        idx   = addr[9:2];
        unit  = addr[9:7];
        dreg  = addr[6:2];
    end
endmodule

// File: rtl/cad_map_ram.sv
`timescale 1ns/1ps
module cad_map_ram #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 21
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] addr,
    input  logic [WIDTH-1:0]         wdata,
    output logic [WIDTH-1:0]         rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/chan_adapter_regs.sv
`timescale 1ns/1ps
module chan_adapter_regs
    import cad_pkg::*;
#(
    parameter int         MAP_DEPTH = 16,
    parameter int         MAP_W     = 21,
    parameter int         VA_W      = 18,
    parameter int         BC_W      = 16,
    parameter logic [7:0] TYPE_CODE = 8'h20,
    parameter logic [4:0] DT_FN     = 5'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_long,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [31:0]       acc_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_nxm,
    output logic              err_confirm,
    output logic              drv_sel,
    output logic              drv_write,
    output logic [2:0]        drv_unit,
    output logic [4:0]        drv_index,
    output logic [15:0]       drv_wdata,
    input  logic [15:0]       drv_rdata,
    input  logic              drv_missing,
    input  logic              drv_noreg,
    output logic              xfer_busy,
    output logic              xfer_abort,
    input  logic              xfer_done,
    output logic              irq
);
    localparam int         MAP_IW  = $clog2(MAP_DEPTH);
    localparam logic [8:0] MAP_LIM = 9'(MAP_DEPTH);

    typedef struct packed {
        logic              cfg_fault;
        logic              maint;
        logic              ie;
        logic              busy;
        logic              irq_pend;
        logic              st_done;
        logic              st_abt;
        logic              st_nxd;
        logic              st_pge;
        logic [15:0]       diag;
        logic [VA_W-1:0]   va;
        logic [BC_W-1:0]   bc;
        logic              rsp_v;
        logic [31:0]       rsp_d;
        logic              rsp_nxm;
        logic              rsp_err;
        logic              abort_p;
    } state_t;

    state_t q, d;

    logic             fault;
    acc_class_e       cls;
    logic [7:0]       idx;
    logic [2:0]       unit;
    logic [4:0]       dreg;
    logic             map_we;
    logic [MAP_W-1:0] map_rdata;

    cad_decode u_dec (
        .valid   (acc_valid),
        .long_sz (acc_long),
        .addr    (acc_addr),
        .fault   (fault),
        .cls     (cls),
        .idx     (idx),
        .unit    (unit),
        .dreg    (dreg)
    );

    cad_map_ram #(.DEPTH(MAP_DEPTH), .WIDTH(MAP_W)) u_map (
        .clk   (clk),
        .we    (map_we),
        .addr  (idx[MAP_IW-1:0]),
        .wdata (acc_wdata[MAP_W-1:0]),
        .rdata (map_rdata)
    );

    function automatic logic [31:0] sts_word(state_t s);
        logic [31:0] w;
        w = '0;
        w[STS_BUSY] = s.busy;
        w[STS_PGE]  = s.st_pge;
        w[STS_NXD]  = s.st_nxd;
        w[STS_ABT]  = s.st_abt;
        w[STS_DONE] = s.st_done;
        return w;
    endfunction

    function automatic state_t clear_sts(state_t s, logic [31:0] mask);
        state_t r;
        r = s;
        if (mask[STS_PGE])  r.st_pge  = 1'b0;
        if (mask[STS_NXD])  r.st_nxd  = 1'b0;
        if (mask[STS_ABT])  r.st_abt  = 1'b0;
        if (mask[STS_DONE]) r.st_done = 1'b0;
        return r;
    endfunction

    function automatic state_t clear_regs(state_t s);
        state_t r;
        r         = '0;
        r.rsp_v   = s.rsp_v;
        r.rsp_d   = s.rsp_d;
        r.rsp_nxm = s.rsp_nxm;
        r.rsp_err = s.rsp_err;
        r.abort_p = s.abort_p;
        return r;
    endfunction

    always_comb begin
        logic is_dt;
        logic maint_w;
        logic do_init;
        d         = q;
        d.rsp_v   = acc_valid;
        d.rsp_d   = '0;
        d.rsp_nxm = 1'b0;
        d.rsp_err = 1'b0;
        d.abort_p = 1'b0;
        map_we    = 1'b0;
        drv_sel   = 1'b0;
        do_init   = 1'b0;
        maint_w   = 1'b0;
        is_dt     = acc_write && (dreg == 5'd0) && acc_wdata[0]
                    && (acc_wdata[5:1] >= DT_FN);

        if (fault) begin
            d.rsp_err   = 1'b1;
            d.cfg_fault = 1'b1;
        end else if (acc_valid) begin
            unique case (cls)
                CLS_INT: begin
                    if (acc_write) begin
                        unique case (idx)
                            OFS_CFG: if (acc_wdata[CFG_FAULT]) d.cfg_fault = 1'b0;
                            OFS_CTL: begin
                                if (acc_wdata[CTL_INIT]) begin
                                    do_init = 1'b1;
                                    d       = clear_regs(d);
                                end
                                if (acc_wdata[CTL_ABORT] && d.busy) begin
                                    d.abort_p = 1'b1;
                                    d.st_abt  = 1'b1;
                                end
                                maint_w = acc_wdata[CTL_MAINT];
                                if (maint_w && d.busy) begin
                                    d.st_pge = 1'b1;
                                    maint_w  = 1'b0;
                                end
                                d.maint = maint_w;
                                d.ie    = acc_wdata[CTL_IE];
                                if (!acc_wdata[CTL_IE]) d.irq_pend = 1'b0;
                            end
                            OFS_STS:  d = clear_sts(d, acc_wdata & STS_W1C);
                            OFS_DIAG: d.diag = acc_wdata[15:0];
                            OFS_VADDR: begin
                                if (q.busy) d.st_pge = 1'b1;
                                else        d.va = acc_wdata[VA_W-1:0];
                            end
                            OFS_BCNT: begin
                                if (q.busy) d.st_pge = 1'b1;
                                else        d.bc = acc_wdata[BC_W-1:0];
                            end
                            OFS_CMD: ;
                            default: d.rsp_nxm = 1'b1;
                        endcase
                    end else begin
                        unique case (idx)
                            OFS_CFG: begin
                                d.rsp_d[7:0]       = TYPE_CODE;
                                d.rsp_d[CFG_FAULT] = q.cfg_fault;
                            end
                            OFS_CTL: begin
                                d.rsp_d[CTL_MAINT] = q.maint;
                                d.rsp_d[CTL_IE]    = q.ie;
                            end
                            OFS_STS:   d.rsp_d = sts_word(q);
                            OFS_DIAG:  d.rsp_d[15:0] = q.diag;
                            OFS_VADDR: d.rsp_d[VA_W-1:0] = q.va;
                            OFS_BCNT: begin
                                d.rsp_d[BC_W-1:0]       = q.bc;
                                d.rsp_d[16+BC_W-1:16]   = q.bc;
                            end
                            OFS_CMD: ;
                            default: d.rsp_nxm = 1'b1;
                        endcase
                    end
                end
                CLS_DRV: begin
                    if (is_dt && q.busy) begin
                        d.st_pge = 1'b1;
                    end else begin
                        drv_sel = 1'b1;
                        if (drv_noreg) begin
                            d.rsp_nxm = 1'b1;
                        end else begin
                            if (drv_missing) d.st_nxd = 1'b1;
                            if (is_dt && !drv_missing) begin
                                d      = clear_sts(d, STS_W1C);
                                d.busy = 1'b1;
                            end
                            if (!acc_write) d.rsp_d = {sts_word(d)[31:16], drv_rdata};
                        end
                    end
                end
                CLS_MAP: begin
                    if ({1'b0, idx} < MAP_LIM) begin
                        if (acc_write) map_we = 1'b1;
                        else           d.rsp_d[MAP_W-1:0] = map_rdata;
                    end else begin
                        d.rsp_nxm = 1'b1;
                    end
                end
                default: d.rsp_nxm = 1'b1;
            endcase
        end

        if (xfer_done && q.busy && !do_init) begin
            d.busy    = 1'b0;
            d.st_done = 1'b1;
            if (d.ie) d.irq_pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rsp_valid   = q.rsp_v;
    assign rsp_rdata   = q.rsp_d;
    assign rsp_nxm     = q.rsp_nxm;
    assign err_confirm = q.rsp_err;
    assign xfer_busy   = q.busy;
    assign xfer_abort  = q.abort_p;
    assign irq         = q.irq_pend;
    assign drv_write   = acc_write;
    assign drv_unit    = unit;
    assign drv_index   = dreg;
    assign drv_wdata   = acc_wdata[15:0];
endmodule

// File: rtl/cad_checker.sv
`timescale 1ns/1ps
module cad_checker #(
    parameter int         VA_W  = 18,
    parameter logic [4:0] DT_FN = 5'h10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            acc_valid,
    input logic            acc_write,
    input logic            acc_long,
    input logic [11:0]     acc_addr,
    input logic            rsp_valid,
    input logic            rsp_nxm,
    input logic            err_confirm,
    input logic            drv_sel,
    input logic            drv_write,
    input logic [4:0]      drv_index,
    input logic [15:0]     drv_wdata,
    input logic            drv_missing,
    input logic            drv_noreg,
    input logic            xfer_busy,
    input logic            xfer_abort,
    input logic            xfer_done,
    input logic            irq,
    input logic            ie_q,
    input logic [VA_W-1:0] va_q
);
    logic dt_fwd;
    assign dt_fwd = drv_sel && drv_write && (drv_index == 5'd0) && drv_wdata[0]
                    && (drv_wdata[5:1] >= DT_FN);

    a_r12_resp_next: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rsp_valid);

    a_r1_fault_confirm: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && (!acc_long || acc_addr[1:0] != 2'b00)) |=> (err_confirm && !rsp_nxm));

    a_r2_one_error_kind: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_nxm, err_confirm}));

    a_r4_abort_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_abort |-> $past(xfer_busy));

    a_r7_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        dt_fwd |-> !xfer_busy);

    a_r7_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (dt_fwd && !drv_missing && !drv_noreg) |=> xfer_busy);

    a_r5_irq_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ie_q);

    a_r6_va_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_busy && acc_valid && acc_write && acc_long && acc_addr[1:0] == 2'b00
         && acc_addr[11:10] == 2'b00 && acc_addr[9:2] == 8'd4) |=> $stable(va_q));

    a_r13_done_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_busy && xfer_done) |=> !xfer_busy);
endmodule

bind chan_adapter_regs cad_checker #(.VA_W(VA_W), .DT_FN(DT_FN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_write   (acc_write),
    .acc_long    (acc_long),
    .acc_addr    (acc_addr),
    .rsp_valid   (rsp_valid),
    .rsp_nxm     (rsp_nxm),
    .err_confirm (err_confirm),
    .drv_sel     (drv_sel),
    .drv_write   (drv_write),
    .drv_index   (drv_index),
    .drv_wdata   (drv_wdata),
    .drv_missing (drv_missing),
    .drv_noreg   (drv_noreg),
    .xfer_busy   (xfer_busy),
    .xfer_abort  (xfer_abort),
    .xfer_done   (xfer_done),
    .irq         (irq),
    .ie_q        (q.ie),
    .va_q        (q.va)
);

// File: tb/chan_adapter_regs_bench.sv
`timescale 1ns/1ps
module chan_adapter_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0, acc_long = 1'b1;
    logic [11:0] acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic        rsp_valid, rsp_nxm, err_confirm;
    logic [31:0] rsp_rdata;
    logic        drv_sel, drv_write;
    logic [2:0]  drv_unit;
    logic [4:0]  drv_index;
    logic [15:0] drv_wdata, drv_rdata;
    logic        drv_missing, drv_noreg;
    logic        xfer_busy, xfer_abort, irq;
    logic        xfer_done = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    logic finished = 1'b0;
    logic        fwd, r_valid, r_nxm, r_err, r_abort;
    logic [31:0] r_data;

    always #2.5 clk = ~clk;

    chan_adapter_regs u_chan_adapter_regs (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_long(acc_long), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_nxm(rsp_nxm),
        .err_confirm(err_confirm), .drv_sel(drv_sel), .drv_write(drv_write),
        .drv_unit(drv_unit), .drv_index(drv_index), .drv_wdata(drv_wdata),
        .drv_rdata(drv_rdata), .drv_missing(drv_missing), .drv_noreg(drv_noreg),
        .xfer_busy(xfer_busy), .xfer_abort(xfer_abort), .xfer_done(xfer_done),
        .irq(irq)
    );

    // drive model: unit 7 absent, register indices 24 and up absent
    always_comb begin
        drv_rdata   = {5'h0, drv_unit, drv_index, 3'b101};
        drv_missing = drv_sel && (drv_unit == 3'd7);
        drv_noreg   = drv_sel && (drv_index >= 5'd24);
    end

    function automatic logic [11:0] ia(input logic [7:0] ofs);
        return {2'b00, ofs, 2'b00};
    endfunction
    function automatic logic [11:0] da(input logic [2:0] u, input logic [4:0] r);
        return {2'b01, u, r, 2'b00};
    endfunction
    function automatic logic [11:0] ma(input logic [7:0] i);
        return {2'b10, i, 2'b00};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic lng, input logic [11:0] a,
                       input logic [31:0] dat, input logic done = 1'b0);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = w; acc_long = lng; acc_addr = a;
        acc_wdata = dat;  xfer_done = done;
        #1 fwd = drv_sel;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; acc_long = 1'b1; xfer_done = 1'b0;
        r_valid = rsp_valid; r_data = rsp_rdata; r_nxm = rsp_nxm;
        r_err = err_confirm; r_abort = xfer_abort;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        acc(1'b0, 1'b1, a, 32'h0);
        chk(tag, r_data, exp);
    endtask

    task automatic done_pulse();
        @(negedge clk); xfer_done = 1'b1;
        @(negedge clk); xfer_done = 1'b0;
    endtask

    task automatic t_reset();
        rd_chk("R10 cfg type code at reset", ia(8'd0), 32'h0000_0020);
        chk("R12 response valid", {31'b0, r_valid}, 32'd1);
        rd_chk("R3 status at reset", ia(8'd2), 32'h0);
        rd_chk("R4 control at reset", ia(8'd1), 32'h0);
        chk("R13 idle at reset", {30'b0, xfer_busy, irq}, 32'h0);
    endtask

    task automatic t_fault();
        acc(1'b1, 1'b1, ia(8'd4) | 12'h001, 32'h5);
        chk("R1 misaligned err_confirm", {30'b0, r_err, r_nxm}, 32'h2);
        acc(1'b1, 1'b0, ia(8'd4), 32'h6);
        chk("R1 short access err_confirm", {30'b0, r_err, r_nxm}, 32'h2);
        rd_chk("R1 address untouched", ia(8'd4), 32'h0);
        rd_chk("R1 fault flag in cfg", ia(8'd0), 32'h0001_0020);
        acc(1'b1, 1'b1, ia(8'd0), 32'h0001_0000);
        rd_chk("R3 cfg fault w1c", ia(8'd0), 32'h0000_0020);
    endtask

    task automatic t_nxm();
        acc(1'b0, 1'b1, ia(8'd9), 32'h0);
        chk("R2 unknown offset nxm", {31'b0, r_nxm}, 32'd1);
        acc(1'b0, 1'b1, 12'hC00, 32'h0);
        chk("R2 class 3 nxm", {31'b0, r_nxm}, 32'd1);
        acc(1'b0, 1'b1, ma(8'd16), 32'h0);
        chk("R2 map index past depth nxm", {31'b0, r_nxm}, 32'd1);
        acc(1'b0, 1'b1, ia(8'd0), 32'h0);
        chk("R2 known offset no nxm", {31'b0, r_nxm}, 32'd0);
    endtask

    task automatic t_regs();
        acc(1'b1, 1'b1, ia(8'd4), 32'hFFFF_FFFF);
        rd_chk("R10 address width", ia(8'd4), 32'h0003_FFFF);
        acc(1'b1, 1'b1, ia(8'd5), 32'hABCD_1234);
        rd_chk("R10 byte count replicated", ia(8'd5), 32'h1234_1234);
        acc(1'b1, 1'b1, ia(8'd6), 32'h55);
        rd_chk("R10 command reads zero", ia(8'd6), 32'h0);
        acc(1'b1, 1'b1, ia(8'd3), 32'hDEAD_BEEF);
        rd_chk("R10 diagnostic 16 bits", ia(8'd3), 32'h0000_BEEF);
    endtask

    task automatic t_map();
        acc(1'b1, 1'b1, ma(8'd0), 32'hFFFF_FFFF);
        acc(1'b1, 1'b1, ma(8'd15), 32'h0001_2345);
        rd_chk("R11 map entry 0 masked", ma(8'd0), 32'h001F_FFFF);
        rd_chk("R11 map last entry", ma(8'd15), 32'h0001_2345);
    endtask

    task automatic t_drive();
        acc(1'b0, 1'b1, da(3'd2, 5'd3), 32'h0);
        chk("R12 drive port forwarded", {31'b0, fwd}, 32'd1);
        chk("R9 drive read value", r_data, 32'h0000_021D);
        acc(1'b0, 1'b1, da(3'd7, 5'd1), 32'h0);
        chk("R9 R8 missing drive upper half", r_data, 32'h0004_070D);
        rd_chk("R8 nxd status", ia(8'd2), 32'h0004_0000);
        acc(1'b0, 1'b1, da(3'd1, 5'd25), 32'h0);
        chk("R8 missing register nxm", {31'b0, r_nxm}, 32'd1);
    endtask

    task automatic t_start();
        acc(1'b1, 1'b1, da(3'd0, 5'd0), 32'h21);
        chk("R7 start forwarded", {31'b0, fwd}, 32'd1);
        chk("R7 busy after start", {31'b0, xfer_busy}, 32'd1);
        rd_chk("R7 start clears w1c bits", ia(8'd2), 32'h8000_0000);
    endtask

    task automatic t_busy();
        acc(1'b1, 1'b1, ia(8'd4), 32'h111);
        rd_chk("R6 address held while busy", ia(8'd4), 32'h0003_FFFF);
        rd_chk("R6 program error on address", ia(8'd2), 32'h8008_0000);
        acc(1'b1, 1'b1, ia(8'd2), 32'h0008_0000);
        acc(1'b1, 1'b1, ia(8'd5), 32'h77);
        rd_chk("R6 byte count held while busy", ia(8'd5), 32'h1234_1234);
        rd_chk("R6 program error on count", ia(8'd2), 32'h8008_0000);
        acc(1'b1, 1'b1, ia(8'd2), 32'h0008_0000);
        acc(1'b1, 1'b1, da(3'd0, 5'd0), 32'h21);
        chk("R7 second start not forwarded", {31'b0, fwd}, 32'd0);
        rd_chk("R7 second start program error", ia(8'd2), 32'h8008_0000);
        acc(1'b1, 1'b1, ia(8'd2), 32'h0008_0000);
        acc(1'b1, 1'b1, da(3'd0, 5'd0), 32'h03);
        chk("R7 non-transfer GO forwarded", {31'b0, fwd}, 32'd1);
        rd_chk("R7 non-transfer GO no error", ia(8'd2), 32'h8000_0000);
        acc(1'b1, 1'b1, ia(8'd1), 32'h4);
        rd_chk("R5 maintenance dropped", ia(8'd1), 32'h0);
        rd_chk("R5 maintenance program error", ia(8'd2), 32'h8008_0000);
        acc(1'b1, 1'b1, ia(8'd2), 32'h0008_0000);
    endtask

    task automatic t_abort_collide();
        acc(1'b1, 1'b1, ia(8'd1), 32'h2);
        chk("R4 abort strobe while busy", {31'b0, r_abort}, 32'd1);
        rd_chk("R4 aborted status", ia(8'd2), 32'h8002_0000);
        acc(1'b1, 1'b1, ia(8'd4), 32'h222, 1'b1);
        chk("R13 done clears busy", {31'b0, xfer_busy}, 32'd0);
        rd_chk("R13 collision refused write", ia(8'd4), 32'h0003_FFFF);
        rd_chk("R13 collision status", ia(8'd2), 32'h000B_0000);
        acc(1'b1, 1'b1, ia(8'd1), 32'h2);
        chk("R4 abort idle no strobe", {31'b0, r_abort}, 32'd0);
        rd_chk("R4 abort idle no status", ia(8'd2), 32'h000B_0000);
    endtask

    task automatic t_w1c();
        acc(1'b1, 1'b1, ia(8'd2), 32'h0001_0000);
        rd_chk("R3 clears only written ones", ia(8'd2), 32'h000A_0000);
        acc(1'b1, 1'b1, ia(8'd2), 32'hFFFF_FFFF);
        rd_chk("R3 clear all w1c", ia(8'd2), 32'h0);
    endtask

    task automatic t_irq();
        acc(1'b1, 1'b1, ia(8'd1), 32'h8);
        acc(1'b1, 1'b1, da(3'd3, 5'd0), 32'h21);
        done_pulse();
        chk("R5 irq on completion", {31'b0, irq}, 32'd1);
        rd_chk("R13 done status", ia(8'd2), 32'h0001_0000);
        acc(1'b1, 1'b1, ia(8'd1), 32'h0);
        chk("R5 clearing enable drops irq", {31'b0, irq}, 32'd0);
        acc(1'b1, 1'b1, ia(8'd2), 32'h0001_0000);
        acc(1'b1, 1'b1, da(3'd3, 5'd0), 32'h21);
        acc(1'b1, 1'b1, ia(8'd2), 32'h0001_0000, 1'b1);
        rd_chk("R3 hardware set wins", ia(8'd2), 32'h0001_0000);
    endtask

    task automatic t_init();
        acc(1'b1, 1'b1, ia(8'd4), 32'h5);
        acc(1'b1, 1'b1, da(3'd0, 5'd0), 32'h21);
        acc(1'b1, 1'b1, ia(8'd1), 32'h1);
        chk("R4 init clears busy", {31'b0, xfer_busy}, 32'd0);
        rd_chk("R4 init clears status", ia(8'd2), 32'h0);
        rd_chk("R4 init clears address", ia(8'd4), 32'h0);
        rd_chk("R4 init clears count", ia(8'd5), 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_fault();
        t_nxm();
        t_regs();
        t_map();
        t_drive();
        t_start();
        t_busy();
        t_abort_collide();
        t_w1c();
        t_irq();
        t_init();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule